// File: doc/BRIEF.md
# Calendar Time Counter with Deferred Commit

This block keeps wall-clock time: seconds, minutes and hours, plus day of month, month and a 6-bit year offset counted from base year 2010. A one-cycle pulse on `tick_i` advances the count by one second. Seconds carry into minutes, minutes into hours, and hours into the day. The day carries into the month using the month's length, and the month carries into the year. February's length depends on a leap flag that software supplies with the date.

Software reaches the block through a small word-addressed register port. The port has a write strobe, a write data bus and a combinational read data bus. The time-of-day word and the date word are loaded separately. A load does not reach the running counters at once. It is held in a staging register, and each word has its own busy flag that stays high until the staged value is committed a fixed number of clock cycles later. Software polls the busy flag before it issues the next load.

Top module: `rtc_cal_core`

## Requirements
- R1: After reset the control word reads 0, the time word reads 0 (00:00:00) and the date word reads 0x00000101 (day 1, month 1, year offset 0, leap flag 0).
- R2: Address 0x0 is control, with bit 8 = time busy and bit 7 = date busy. Address 0x4 is date, with day in bits 4:0, month in bits 11:8, year offset in bits 21:16 and leap flag in bit 22. Address 0x8 is time, with seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. Unused bits read 0, and every other address reads 0.
- R3: A write to 0x8 sets bit 8 of control, and a write to 0x4 sets bit 7, both from the next cycle. Write data in bits outside the fields is ignored.
- R4: A load reaches the counters exactly COMMIT_CYC (default 3) clock edges after the edge that captured the write. The busy bit clears on that same edge, and until then reads return the previous value.
- R5: A second write to the same word while it is busy discards the first value and restarts the full commit delay with the new value.
- R6: On a tick, seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, and hours wrap from 23 to 0 and advance the day.
- R7: The day wraps to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in the other months apart from February, advancing the month.
- R8: February ends after day 28 when the leap flag is 0 and after day 29 when it is 1.
- R9: After day 31 of month 12 the date becomes day 1 of month 1 and the year offset increments, wrapping from 63 to 0. The leap flag is kept.
- R10: On an edge where the time commit fires, the loaded time wins and that tick is dropped. On an edge where the date commit fires, the loaded date wins over any day carry, while the time fields still advance.
- R11: Writes to the control address or to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second advance pulse, one cycle wide |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |

## Verification
The bench goes after the carry chain at its edges. It checks 59 to 0 at each time level, the 30-day and 31-day months, February with and without the leap flag, the end of the year, and the year offset wrapping from 63 to 0. A wrong month-length decode would show the wrong day after the last day of the month, and a dropped leap flag would read as March 1 where February 29 is expected. The bench samples busy and value on every cycle of the commit window, so a commit that is one cycle early or late is caught. It also overwrites a pending load, which catches a design that commits the stale value at the old deadline. Ticks are placed exactly on commit edges, which exposes a design that adds one second to a freshly loaded time or lets a day carry overwrite a loaded date.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int SC_W  = 6;
  localparam int MN_W  = 6;
  localparam int HR_W  = 5;
  localparam int DAY_W = 5;
  localparam int MON_W = 4;
  localparam int YR_W  = 6;

  typedef struct packed {
    logic [HR_W-1:0] hr;
    logic [MN_W-1:0] mn;
    logic [SC_W-1:0] sc;
  } tod_t;

  typedef struct packed {
    logic            leap;
    logic [YR_W-1:0] yr;
    logic [MON_W-1:0] mon;
    logic [DAY_W-1:0] day;
  } ymd_t;

  // field positions are software-visible
  function automatic logic [31:0] tod_word(tod_t t);
    logic [31:0] w;
    w = '0;
    w[5:0]   = t.sc;
    w[13:8]  = t.mn;
    w[20:16] = t.hr;
    return w;
  endfunction

  function automatic logic [31:0] ymd_word(ymd_t d);
    logic [31:0] w;
    w = '0;
    w[4:0]   = d.day;
    w[11:8]  = d.mon;
    w[21:16] = d.yr;
    w[22]    = d.leap;
    return w;
  endfunction

  function automatic tod_t word_tod(logic [31:0] w);
    tod_t t;
    t.sc = w[5:0];
    t.mn = w[13:8];
    t.hr = w[20:16];
    return t;
  endfunction

  function automatic ymd_t word_ymd(logic [31:0] w);
    ymd_t d;
    d.day  = w[4:0];
    d.mon  = w[11:8];
    d.yr   = w[21:16];
    d.leap = w[22];
    return d;
  endfunction

  function automatic logic [DAY_W-1:0] month_len(logic [MON_W-1:0] mon, logic leap);
    case (mon)
      4'd2:                   return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_commit.sv
module rtc_commit #(
  parameter int W   = 16,
  parameter int CYC = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         busy_o,
  output logic         fire_o,
  output logic [W-1:0] data_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [W-1:0]  stage_q;

  // a reload on the deadline edge suppresses the stale commit
  assign fire_o = busy_q && (cnt_q == '0) && !load_i;
  assign busy_o = busy_q;
  assign data_o = stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      stage_q <= '0;
    end else if (load_i) begin
      cnt_q   <= CW'(CYC - 1);
      busy_q  <= 1'b1;
      stage_q <= data_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ld_tod_i,
  input  tod_t tod_i,
  input  logic ld_ymd_i,
  input  ymd_t ymd_i,
  output tod_t tod_o,
  output ymd_t ymd_o
);
  tod_t tod_q;
  ymd_t ymd_q;
  logic sc_end, mn_end, hr_end, day_end, mon_end, roll_day;

  // >= so out-of-range loads still wrap
  always_comb begin
    sc_end   = tod_q.sc >= 6'd59;
    mn_end   = tod_q.mn >= 6'd59;
    hr_end   = tod_q.hr >= 5'd23;
    day_end  = ymd_q.day >= month_len(ymd_q.mon, ymd_q.leap);
    mon_end  = ymd_q.mon >= 4'd12;
    roll_day = tick_i && !ld_tod_i && sc_end && mn_end && hr_end;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tod_q <= '0;
    end else if (ld_tod_i) begin
      tod_q <= tod_i;
    end else if (tick_i) begin
      tod_q.sc <= sc_end ? '0 : tod_q.sc + 1'b1;
      if (sc_end) tod_q.mn <= mn_end ? '0 : tod_q.mn + 1'b1;
      if (sc_end && mn_end) tod_q.hr <= hr_end ? '0 : tod_q.hr + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ymd_q      <= '0;
      ymd_q.day  <= 5'd1;
      ymd_q.mon  <= 4'd1;
    end else if (ld_ymd_i) begin
      ymd_q <= ymd_i;
    end else if (roll_day) begin
      if (day_end) begin
        ymd_q.day <= 5'd1;
        if (mon_end) begin
          ymd_q.mon <= 4'd1;
          ymd_q.yr  <= ymd_q.yr + 1'b1;
        end else begin
          ymd_q.mon <= ymd_q.mon + 1'b1;
        end
      end else begin
        ymd_q.day <= ymd_q.day + 1'b1;
      end
    end
  end

  assign tod_o = tod_q;
  assign ymd_o = ymd_q;
endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
  import rtc_cal_pkg::*;
#(
  parameter int              ADDR_W     = 4,
  parameter int              COMMIT_CYC = 3,
  parameter logic [ADDR_W-1:0] CTRL_A   = 'h0,
  parameter logic [ADDR_W-1:0] DATE_A   = 'h4,
  parameter logic [ADDR_W-1:0] TIME_A   = 'h8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  localparam int TOD_W = $bits(tod_t);
  localparam int YMD_W = $bits(ymd_t);

  logic             t_busy, t_fire, d_busy, d_fire;
  logic [TOD_W-1:0] t_stage;
  logic [YMD_W-1:0] d_stage;
  tod_t             tod_cur;
  ymd_t             ymd_cur;
  logic [31:0]      time_word, date_word, t_stage_word;
  logic             unused_wdata;

  assign unused_wdata = ^{wdata_i[31:23], wdata_i[15:14], wdata_i[7:6]};

  rtc_commit #(.W(TOD_W), .CYC(COMMIT_CYC)) u_tod_commit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (we_i && addr_i == TIME_A),
    .data_i (word_tod(wdata_i)),
    .busy_o (t_busy),
    .fire_o (t_fire),
    .data_o (t_stage)
  );

  rtc_commit #(.W(YMD_W), .CYC(COMMIT_CYC)) u_ymd_commit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (we_i && addr_i == DATE_A),
    .data_i (word_ymd(wdata_i)),
    .busy_o (d_busy),
    .fire_o (d_fire),
    .data_o (d_stage)
  );

  rtc_calendar u_cal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .ld_tod_i (t_fire),
    .tod_i    (tod_t'(t_stage)),
    .ld_ymd_i (d_fire),
    .ymd_i    (ymd_t'(d_stage)),
    .tod_o    (tod_cur),
    .ymd_o    (ymd_cur)
  );

  assign time_word    = tod_word(tod_cur);
  assign date_word    = ymd_word(ymd_cur);
  assign t_stage_word = tod_word(tod_t'(t_stage));

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_A) begin
      rdata_o[8] = t_busy;
      rdata_o[7] = d_busy;
    end else if (addr_i == DATE_A) begin
      rdata_o = date_word;
    end else if (addr_i == TIME_A) begin
      rdata_o = time_word;
    end
  end
endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk #(
  parameter int AW  = 4,
  parameter int CYC = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [31:0]   rdata_o,
  input logic          t_busy,
  input logic          t_fire,
  input logic [31:0]   time_word,
  input logic [31:0]   t_stage_word
);
  a_r3_time_busy_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(8)) |=> t_busy);

  a_r4_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((CYC > 1) && $rose(t_busy)) |=> t_busy);

  a_r4_commit_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(t_busy) |-> (time_word == $past(t_stage_word)));

  a_r6_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !t_fire && time_word[5:0] == 6'd59) |=> (time_word[5:0] == 6'd0));

  a_r2_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != AW'(0) && addr_i != AW'(4) && addr_i != AW'(8)) |-> (rdata_o == 32'd0));
endmodule

bind rtc_cal_core rtc_cal_chk #(.AW(ADDR_W), .CYC(COMMIT_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .rdata_o      (rdata_o),
  .t_busy       (t_busy),
  .t_fire       (t_fire),
  .time_word    (time_word),
  .t_stage_word (t_stage_word)
);

// File: tb/sim_rtc_cal_core.sv
`timescale 1ns/1ps
module sim_rtc_cal_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  rtc_cal_core u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  function automatic logic [31:0] tw(int h, int m, int s);
    return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  function automatic logic [31:0] dw(int lp, int y, int m, int d);
    return (32'(lp) << 22) | (32'(y) << 16) | (32'(m) << 8) | 32'(d);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic rchk(string req, logic [3:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic write_reg(logic [3:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_tod(int h, int m, int s);
    write_reg(4'h8, tw(h, m, s));
    repeat (3) @(negedge clk);
  endtask

  task automatic set_ymd(int lp, int y, int m, int d);
    write_reg(4'h4, dw(lp, y, m, d));
    repeat (3) @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    rchk("R1 ctrl", 4'h0, 32'h0);
    rchk("R1 time", 4'h8, 32'h0);
    rchk("R1 date", 4'h4, 32'h0000_0101);
  endtask

  task automatic t_map();
    write_reg(4'h8, 32'hFFE0_C0C0 | tw(7, 8, 9));
    repeat (3) @(negedge clk);
    rchk("R3 time junk bits", 4'h8, tw(7, 8, 9));
    write_reg(4'h4, 32'hFF80_F0E0 | dw(1, 5, 3, 17));
    repeat (3) @(negedge clk);
    rchk("R3 date junk bits", 4'h4, dw(1, 5, 3, 17));
    rchk("R2 unmapped read", 4'hC, 32'h0);
    rchk("R2 ctrl idle", 4'h0, 32'h0);
  endtask

  task automatic t_commit();
    set_tod(1, 2, 3);
    write_reg(4'h8, tw(4, 5, 6));
    rchk("R3 time busy", 4'h0, 32'h100);
    rchk("R4 old time c1", 4'h8, tw(1, 2, 3));
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      rchk("R4 time busy hold", 4'h0, 32'h100);
      rchk("R4 old time", 4'h8, tw(1, 2, 3));
    end
    @(negedge clk);
    rchk("R4 time busy clear", 4'h0, 32'h0);
    rchk("R4 time committed", 4'h8, tw(4, 5, 6));
    set_ymd(0, 1, 1, 1);
    write_reg(4'h4, dw(0, 2, 6, 9));
    rchk("R3 date busy", 4'h0, 32'h80);
    repeat (2) @(negedge clk);
    rchk("R4 date busy hold", 4'h0, 32'h80);
    rchk("R4 old date", 4'h4, dw(0, 1, 1, 1));
    @(negedge clk);
    rchk("R4 date busy clear", 4'h0, 32'h0);
    rchk("R4 date committed", 4'h4, dw(0, 2, 6, 9));
  endtask

  task automatic t_restart();
    set_tod(0, 0, 0);
    write_reg(4'h8, tw(1, 1, 1));
    write_reg(4'h8, tw(2, 2, 2));
    repeat (2) @(negedge clk);
    rchk("R5 no stale commit", 4'h8, tw(0, 0, 0));
    rchk("R5 still busy", 4'h0, 32'h100);
    @(negedge clk);
    rchk("R5 newest value", 4'h8, tw(2, 2, 2));
    rchk("R5 busy clear", 4'h0, 32'h0);
  endtask

  task automatic t_time_roll();
    set_ymd(0, 0, 1, 5);
    set_tod(0, 0, 58);
    do_tick();
    rchk("R6 plain tick", 4'h8, tw(0, 0, 59));
    do_tick();
    rchk("R6 sec wrap", 4'h8, tw(0, 1, 0));
    set_tod(0, 59, 59);
    do_tick();
    rchk("R6 min wrap", 4'h8, tw(1, 0, 0));
    set_tod(23, 59, 59);
    do_tick();
    rchk("R6 hour wrap", 4'h8, tw(0, 0, 0));
    rchk("R6 day advance", 4'h4, dw(0, 0, 1, 6));
  endtask

  task automatic roll_date(int lp, int y, int m, int d);
    set_ymd(lp, y, m, d);
    set_tod(23, 59, 59);
    do_tick();
  endtask

  task automatic t_month();
    roll_date(0, 3, 4, 30);
    rchk("R7 30-day month end", 4'h4, dw(0, 3, 5, 1));
    roll_date(0, 3, 1, 30);
    rchk("R7 31-day month no roll", 4'h4, dw(0, 3, 1, 31));
    set_tod(23, 59, 59);
    do_tick();
    rchk("R7 31-day month end", 4'h4, dw(0, 3, 2, 1));
    roll_date(0, 3, 11, 30);
    rchk("R7 november end", 4'h4, dw(0, 3, 12, 1));
  endtask

  task automatic t_feb();
    roll_date(0, 4, 2, 28);
    rchk("R8 feb common", 4'h4, dw(0, 4, 3, 1));
    roll_date(1, 2, 2, 28);
    rchk("R8 feb leap 29", 4'h4, dw(1, 2, 2, 29));
    set_tod(23, 59, 59);
    do_tick();
    rchk("R8 feb leap end", 4'h4, dw(1, 2, 3, 1));
  endtask

  task automatic t_year();
    roll_date(0, 5, 12, 31);
    rchk("R9 year step", 4'h4, dw(0, 6, 1, 1));
    rchk("R9 midnight", 4'h8, tw(0, 0, 0));
    roll_date(1, 63, 12, 31);
    rchk("R9 year wrap", 4'h4, dw(1, 0, 1, 1));
  endtask

  task automatic t_collide();
    set_tod(10, 20, 30);
    write_reg(4'h8, tw(11, 0, 0));
    repeat (2) @(negedge clk);
    do_tick();
    rchk("R10 tick dropped on time commit", 4'h8, tw(11, 0, 0));
    set_ymd(0, 9, 6, 14);
    set_tod(23, 59, 59);
    write_reg(4'h4, dw(0, 9, 6, 20));
    repeat (2) @(negedge clk);
    do_tick();
    rchk("R10 loaded date wins", 4'h4, dw(0, 9, 6, 20));
    rchk("R10 time still ticks", 4'h8, tw(0, 0, 0));
  endtask

  task automatic t_ignore();
    set_tod(5, 6, 7);
    set_ymd(1, 8, 9, 10);
    write_reg(4'h0, 32'hFFFF_FFFF);
    rchk("R11 ctrl write ignored", 4'h0, 32'h0);
    repeat (4) @(negedge clk);
    rchk("R11 ctrl write ignored later", 4'h0, 32'h0);
    write_reg(4'hC, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    rchk("R11 unmapped write read", 4'hC, 32'h0);
    rchk("R11 time kept", 4'h8, tw(5, 6, 7));
    rchk("R11 date kept", 4'h4, dw(1, 8, 9, 10));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_commit();
    t_restart();
    t_time_roll();
    t_month();
    t_feb();
    t_year();
    t_collide();
    t_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule